// File: doc/BRIEF.md
# Programmable Reference Clock Divider

This block takes a free-running reference clock and produces a divided copy of it for neighbouring devices. A three-bit setting selects the ratio. Ratios 1, 2, 3, 4, 5, 6 and 8 are available. The output keeps an even split between high and low time for every ratio. For odd ratios this needs logic on both edges of the reference clock. For ratio 1 the reference clock is gated straight through. The block has no enable or standby input, so once reset is released it runs continuously, whatever power state the rest of the device is in.

The setting is read only at the end of an output period. A change part way through a period therefore never produces a runt pulse. A four-state phase machine on the rising edge drives the output. Its states are PH_IDLE (after reset, waiting for the first boundary), PH_PASS (pass-through for ratio 1), PH_HIGH (the high part of a divided period) and PH_LOW (the low part).

- PH_IDLE or PH_PASS moves to PH_HIGH when the setting selects a ratio above 1.
- PH_IDLE or PH_PASS moves to PH_PASS when the setting selects ratio 1.
- PH_HIGH moves to PH_LOW after floor(N/2) reference cycles.
- PH_LOW moves to PH_HIGH or PH_PASS at the period boundary, after N reference cycles in total.

A falling-edge stage stretches the high part by half a reference cycle for odd N. A second falling-edge stage opens the pass-through gate only while the reference clock is low.

Top module: `refclk_ratio_div`

## Requirements
- R1: While rst_n is low, clk_div is low. After release it stays low until the first rising reference edge, where the first output period begins.
- R2: The setting ratio_sel selects the ratio N in reference cycles per output period: 000→1, 001→2, 010→2, 011→3, 100→4, 101→5, 110→6, 111→8.
- R3: For even N, clk_div is high for N/2 reference cycles from a rising reference edge, then low for N/2 cycles.
- R4: For odd N of 3 or more, clk_div is high for N/2 reference cycles (a whole number plus one half), falling on a falling reference edge, then low for the same time.
- R5: For N = 1, clk_div follows clk_ref.
- R6: ratio_sel is sampled only at a period boundary. A change, or a change and return, during a period leaves that period's high and low times unchanged, and a new setting first applies to the following period.
- R7: On a switch from a divided ratio into N = 1, the last divided period is followed by one full reference cycle of low output, and clk_div then follows clk_ref from the next rising edge.
- R8: On a switch out of N = 1, the divided period starts at the next rising reference edge with its full high time and no shortened pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 3 | Encoded division ratio setting |
| clk_div | output | 1 | Divided reference output |

## Verification
The assertions assume that clk_ref runs freely with a clean waveform. They also assume that ratio_sel and the release of rst_n never change on a reference edge, so that the rising-edge phase machine and the falling-edge stages always sample settled values. The stimulus drives ratio_sel one nanosecond after a rising reference edge and releases reset half a nanosecond after a falling edge. Each change is made just after the monitor has seen a new output period start, so each expected high and low time can be predicted from the setting in force at the start and at the end of that period.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int SEL_W   = 3;
    localparam int RATIO_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PASS = 2'd1,
        PH_HIGH = 2'd2,
        PH_LOW  = 2'd3
    } phase_e;

    function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [SEL_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            3'b000:  r = RATIO_W'(1);
            3'b001:  r = RATIO_W'(2);
            3'b010:  r = RATIO_W'(2);
            3'b011:  r = RATIO_W'(3);
            3'b100:  r = RATIO_W'(4);
            3'b101:  r = RATIO_W'(5);
            3'b110:  r = RATIO_W'(6);
            default: r = RATIO_W'(8);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
    import refdiv_pkg::*;
(
    input  logic [SEL_W-1:0]   code_i,
    output logic [RATIO_W-1:0] ratio_o
);

    always_comb begin
        ratio_o = code_to_ratio(code_i);
    end

endmodule

// File: rtl/refdiv_fsm.sv
module refdiv_fsm
    import refdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_req,
    output phase_e             state_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [RATIO_W-1:0] cnt_o,
    output logic               hi_p_o
);

    phase_e             state_q, state_d;
    logic [RATIO_W-1:0] ratio_q, ratio_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] half_len;
    logic               last_cycle;

    assign half_len   = ratio_q >> 1;
    assign last_cycle = (cnt_q == ratio_q - RATIO_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            ratio_q <= RATIO_W'(1);
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            ratio_q <= ratio_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        ratio_d = ratio_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_IDLE, PH_PASS: begin
                ratio_d = ratio_req;
                cnt_d   = '0;
                state_d = (ratio_req == RATIO_W'(1)) ? PH_PASS : PH_HIGH;
            end
            PH_HIGH: begin
                cnt_d = cnt_q + RATIO_W'(1);
                if (cnt_q == half_len - RATIO_W'(1)) begin
                    state_d = PH_LOW;
                end
            end
            PH_LOW: begin
                if (last_cycle) begin
                    ratio_d = ratio_req;
                    cnt_d   = '0;
                    state_d = (ratio_req == RATIO_W'(1)) ? PH_PASS : PH_HIGH;
                end else begin
                    cnt_d = cnt_q + RATIO_W'(1);
                end
            end
            default: begin
                state_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        hi_p_o  = (state_q == PH_HIGH);
        state_o = state_q;
        ratio_o = ratio_q;
        cnt_o   = cnt_q;
    end

endmodule

// File: rtl/refdiv_edge.sv
module refdiv_edge
    import refdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e state_i,
    input  logic   odd_i,
    input  logic   hi_p_i,
    output logic   hi_n_o,
    output logic   clk_out
);

    logic byp_en_q;
    logic hi_n_q;

    // falling-edge stages: half-cycle stretch and pass-through gate
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_n_q   <= 1'b0;
            byp_en_q <= 1'b0;
        end else begin
            hi_n_q   <= hi_p_i & odd_i;
            byp_en_q <= (state_i == PH_PASS);
        end
    end

    always_comb begin
        hi_n_o  = hi_n_q;
        clk_out = (byp_en_q & clk) | hi_p_i | hi_n_q;
    end

endmodule

// File: rtl/refclk_ratio_div.sv
module refclk_ratio_div
    import refdiv_pkg::*;
(
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             clk_div
);

    logic [RATIO_W-1:0] ratio_req;
    logic [RATIO_W-1:0] ratio_cur;
    logic [RATIO_W-1:0] cnt;
    phase_e             fsm_state;
    logic               hi_p;
    logic               hi_n;

    refdiv_decode u_decode (
        .code_i  (ratio_sel),
        .ratio_o (ratio_req)
    );

    refdiv_fsm u_fsm (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .ratio_req (ratio_req),
        .state_o   (fsm_state),
        .ratio_o   (ratio_cur),
        .cnt_o     (cnt),
        .hi_p_o    (hi_p)
    );

    refdiv_edge u_edge (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .state_i (fsm_state),
        .odd_i   (ratio_cur[0]),
        .hi_p_i  (hi_p),
        .hi_n_o  (hi_n),
        .clk_out (clk_div)
    );

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
    import refdiv_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [SEL_W-1:0]   sel,
    input logic               clk_out,
    input phase_e             state,
    input logic [RATIO_W-1:0] ratio_cur,
    input logic [RATIO_W-1:0] cnt,
    input logic               hi_n
);

    logic at_boundary;
    assign at_boundary = (state == PH_IDLE) || (state == PH_PASS) ||
                         ((state == PH_LOW) && (cnt == ratio_cur - RATIO_W'(1)));

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_LOW: assert (!clk_out); // R1
        end
    end

    AST_RATIO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        at_boundary |=> (ratio_cur == code_to_ratio($past(sel)))); // R2

    AST_LOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LOW) |-> (cnt < ratio_cur)); // R2

    AST_HIGH_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH) |-> (cnt < (ratio_cur >> 1))); // R3

    AST_ODD_TAIL: assert property (@(negedge clk) disable iff (!rst_n)
        hi_n |-> ratio_cur[0]); // R4

    AST_PASS_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_PASS) |-> (ratio_cur == RATIO_W'(1))); // R5

    AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH) |=> $stable(ratio_cur)); // R6

endmodule

bind refclk_ratio_div refdiv_chk u_chk (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .sel       (ratio_sel),
    .clk_out   (clk_div),
    .state     (fsm_state),
    .ratio_cur (ratio_cur),
    .cnt       (cnt),
    .hi_n      (hi_n)
);

// File: tb/refclk_ratio_div_tb.sv
`timescale 1ns/100ps
module refclk_ratio_div_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'b001;
    logic       clk_div;

    always #2 clk = ~clk;   // 250 MHz

    refclk_ratio_div u_dut (
        .clk_ref   (clk),
        .rst_n     (rst_n),
        .ratio_sel (sel),
        .clk_div   (clk_div)
    );

    int    checks = 0;
    int    errors = 0;
    int    q_hi[$];
    int    q_lo[$];
    string q_tag[$];
    event  rise_ev;
    bit    started = 0;
    bit    done = 0;
    int    hi_run = 0;
    int    lo_run = 0;
    logic  prev_v = 1'b0;
    int    cur = 2;
    int    prev_n = 2;

    // monitor: one sample per half reference cycle, period compare from queue
    always @(posedge clk or negedge clk) begin
        #1;
        if (!rst_n) begin
            checks++;
            if (clk_div !== 1'b0) begin
                errors++;
                $display("FAIL R1 output during reset: actual %b expected 0", clk_div);
            end
        end else if (!done) begin
            if (clk_div === 1'b1 && prev_v === 1'b0) begin
                if (started) begin
                    if (q_hi.size() == 0) begin
                        errors++;
                        $display("FAIL R2 period with no expectation: actual hi %0d lo %0d expected none",
                                 hi_run, lo_run);
                    end else begin
                        int    eh;
                        int    el;
                        string tg;
                        eh = q_hi.pop_front();
                        el = q_lo.pop_front();
                        tg = q_tag.pop_front();
                        checks++;
                        if (hi_run != eh || lo_run != el) begin
                            errors++;
                            $display("FAIL %s half-cycles: actual hi %0d lo %0d expected hi %0d lo %0d",
                                     tg, hi_run, lo_run, eh, el);
                        end
                    end
                end else begin
                    checks++;
                    if (lo_run != 1) begin
                        errors++;
                        $display("FAIL R1 low samples before first rise: actual %0d expected 1", lo_run);
                    end
                end
                started = 1;
                hi_run  = 1;
                lo_run  = 0;
                prev_v  = 1'b1;
                ->rise_ev;
            end else begin
                if (clk_div === 1'b1) hi_run++;
                else lo_run++;
                prev_v = clk_div;
            end
        end
    end

    // driver: at each period start, push the expectation for that period
    task automatic step(input logic [2:0] code, input int n);
        int    old;
        int    lo;
        string tag;
        @(rise_ev);
        old = cur;
        sel = code;
        lo  = old + ((n == 1 && old != 1) ? 2 : 0);
        if (prev_n == 1 && old != 1)       tag = "R8";
        else if (n == 1 && old != 1)       tag = "R7";
        else if (old != n)                 tag = "R6";
        else if (code == 3'b010)           tag = "R2";
        else if (old == 1)                 tag = "R5";
        else if (old % 2 == 1)             tag = "R4,R2";
        else                               tag = "R3,R2";
        q_hi.push_back(old);
        q_lo.push_back(lo);
        q_tag.push_back(tag);
        prev_n = old;
        cur    = n;
    endtask

    task automatic hold(input logic [2:0] code, input int n, input int count);
        for (int i = 0; i < count; i++) step(code, n);
    endtask

    // mid-period disturbance that must have no effect (R6)
    task automatic poke(input logic [2:0] code);
        @(rise_ev);
        sel = 3'b111;
        #5;
        sel = code;
        q_hi.push_back(cur);
        q_lo.push_back(cur);
        q_tag.push_back("R6");
        prev_n = cur;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        #0.5;
        rst_n = 1'b1;
        hold(3'b001, 2, 3);
        hold(3'b011, 3, 4);
        hold(3'b100, 4, 3);
        poke(3'b100);
        hold(3'b100, 4, 1);
        hold(3'b101, 5, 3);
        hold(3'b110, 6, 3);
        poke(3'b110);
        hold(3'b111, 8, 3);
        hold(3'b010, 2, 3);
        hold(3'b000, 1, 5);
        hold(3'b101, 5, 3);
        hold(3'b000, 1, 4);
        hold(3'b110, 6, 3);
        hold(3'b000, 1, 3);
        hold(3'b011, 3, 3);
        hold(3'b001, 2, 2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL R2 watchdog expired: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule